// File: doc/BRIEF.md
# Source Packet Late Decision Checker

This block decides, one packet at a time, whether an isochronous source packet is still on time. Each packet carries a timestamp in cycle-timer format: a 13-bit bus-cycle count running 0..7999, and a 12-bit offset inside the cycle running 0..3071. The block subtracts the live cycle-timer value from that timestamp with wrap-around arithmetic and compares the result against a window that software programs.

A transmit packet inside the window is passed on at once. A receive packet inside the window is parked in a single hold slot and released in the cycle after the timer reaches its timestamp. A packet outside the window is dropped, and a direction-specific late pulse is raised and latched into a sticky status bit. Packet parsing, data storage and the link layer sit outside this block. Only the accept/release/drop decision and its pulses are produced here.

Top module: `pkt_late_judge`

## Requirements
- R1: The window register is at address 0x40, is 16 bits, can be read and written, and resets to 0x0000. Bits 15:8 hold whole bus cycles. Bits 7:0 hold sub-cycle units of 16 offset ticks.
- R2: The threshold, in ticks, is bits[15:8]*3072 + bits[7:0]*16. A difference d is in range when 0 <= d <= threshold, so d equal to the threshold is accepted and threshold+16 is not.
- R3: A transmit packet (pkt_rx_i=0) that is in range gives a one-cycle pkt_go_o in the cycle after it is accepted, with no drop.
- R4: A packet that is out of range gives pkt_drop_o together with exactly one late pulse in the cycle after it is accepted: tx_late_o for transmit, rx_late_o for receive. This includes a negative difference, meaning a wrapped difference of 4000 cycles or more.
- R5: A receive packet (pkt_rx_i=1) with a non-zero in-range difference is held. While it is held, pkt_ready_o is low and there is no go. pkt_go_o pulses, and pkt_ready_o returns high, in the cycle after cyc_time_i equals the stored timestamp.
- R6: A receive packet with a difference of exactly zero is released at once, like a transmit packet.
- R7: The status register is at 0x41. Bit 0 holds sticky transmit-late and bit 1 holds sticky receive-late. Writing 1 to a bit clears it. A new late event wins over a clear in the same cycle. Both bits reset to 0.
- R8: pkt_valid_i is ignored while pkt_ready_o is low. Such a packet causes no drop, no late pulse and no go.
- R9: The difference borrows from the cycle count when the offset underflows, and wraps modulo 8000 cycles. A timestamp shortly after a cycle-count wrap is therefore judged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on address) |
| cyc_time_i | input | 25 | Live cycle timer {count[12:0], offset[11:0]} |
| pkt_valid_i | input | 1 | Packet timestamp present |
| pkt_rx_i | input | 1 | Direction: 0 transmit, 1 receive |
| pkt_stamp_i | input | 25 | Packet timestamp {count[12:0], offset[11:0]} |
| pkt_ready_o | output | 1 | Hold slot free; packets are taken only when high |
| pkt_go_o | output | 1 | Pulse: packet forwarded or released |
| pkt_drop_o | output | 1 | Pulse: packet discarded as late |
| tx_late_o | output | 1 | Pulse: transmit packet late |
| rx_late_o | output | 1 | Pulse: receive packet late |

## Verification
The hardest state to reach is a held receive packet whose release depends on the timer reaching an exact tick, possibly across a cycle-count wrap. Stepping the timer one tick per clock would take hundreds of thousands of cycles. Because the timer is an input, the bench instead jumps it to one tick before the stored timestamp, checks that there is still no release, and then steps onto the timestamp. While the slot is full, the bench also offers a late packet to show that it is ignored.

// File: rtl/plj_pkg.sv
package plj_pkg;
  localparam int unsigned CNT_W = 13;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned TIME_W = CNT_W + OFF_W;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } cyc_time_t;

  typedef enum logic [0:0] {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/plj_regs.sv
module plj_regs #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned N_EVT      = 2,
  parameter logic [7:0]  RANGE_ADDR = 8'h40,
  parameter logic [7:0]  STAT_ADDR  = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [DATA_W-1:0] range_o,
  output logic [N_EVT-1:0]  stat_o
);
  logic [DATA_W-1:0] range_q;
  logic [N_EVT-1:0]  stat_q;
  logic              wr_range, wr_stat;

  assign wr_range = we_i && (addr_i == ADDR_W'(RANGE_ADDR));
  assign wr_stat  = we_i && (addr_i == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       range_q <= '0;
    else if (wr_range) range_q <= wdata_i;
  end

  // sticky, write-one-to-clear; set has priority
  for (genvar i = 0; i < N_EVT; i++) begin : g_stat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= evt_i[i] | (stat_q[i] & ~(wr_stat & wdata_i[i]));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(RANGE_ADDR))     rdata_o = range_q;
    else if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[N_EVT-1:0] = stat_q;
  end

  assign range_o = range_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/plj_diff.sv
module plj_diff
  import plj_pkg::*;
#(
  parameter int unsigned CNT_WRAP = 8000,
  parameter int unsigned OFF_WRAP = 3072,
  parameter int unsigned RANGE_W  = 16
) (
  input  cyc_time_t          stamp_i,
  input  cyc_time_t          now_i,
  input  logic [RANGE_W-1:0] range_i,
  output logic               in_range_o,
  output logic               zero_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned OW   = OFF_W + 1;
  localparam int unsigned HALF = CNT_WRAP / 2;
  localparam int unsigned SUB_W = RANGE_W / 2;

  logic          borrow, cnt_lt, sub_over, neg;
  logic [OW-1:0] doff_w;
  logic [DW-1:0] dcnt_raw, dcnt_w;
  logic [CNT_W-1:0] dcnt, thr_cnt;
  logic [OFF_W-1:0] doff, sub16, thr_off;

  assign borrow   = stamp_i.off < now_i.off;
  assign doff_w   = {1'b0, stamp_i.off} - {1'b0, now_i.off} + (borrow ? OW'(OFF_WRAP) : '0);
  assign doff     = doff_w[OFF_W-1:0];

  assign cnt_lt   = {1'b0, stamp_i.cnt} < ({1'b0, now_i.cnt} + DW'(borrow));
  assign dcnt_raw = {1'b0, stamp_i.cnt} - {1'b0, now_i.cnt} - DW'(borrow);
  assign dcnt_w   = cnt_lt ? dcnt_raw + DW'(CNT_WRAP) : dcnt_raw;
  assign dcnt     = dcnt_w[CNT_W-1:0];

  // threshold normalised to {cycles, ticks} so sub-cycle part stays below one cycle
  assign sub16    = {range_i[SUB_W-1:0], 4'b0000};
  assign sub_over = sub16 >= OFF_W'(OFF_WRAP);
  assign thr_off  = sub_over ? sub16 - OFF_W'(OFF_WRAP) : sub16;
  assign thr_cnt  = CNT_W'(range_i[RANGE_W-1:SUB_W]) + CNT_W'(sub_over);

  assign neg        = dcnt >= CNT_W'(HALF);
  assign in_range_o = !neg && ((dcnt < thr_cnt) || ((dcnt == thr_cnt) && (doff <= thr_off)));
  assign zero_o     = (dcnt == '0) && (doff == '0);
endmodule

// File: rtl/plj_hold.sv
module plj_hold
  import plj_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cyc_time_t stamp_i,
  input  cyc_time_t now_i,
  output logic      busy_o,
  output logic      release_o
);
  logic      busy_q;
  cyc_time_t stamp_q;

  assign release_o = busy_q && (now_i == stamp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      stamp_q <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      stamp_q <= stamp_i;
    end else if (release_o) begin
      busy_q  <= 1'b0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pkt_late_judge.sv
module pkt_late_judge
  import plj_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CNT_WRAP   = 8000,
  parameter int unsigned OFF_WRAP   = 3072,
  parameter logic [7:0]  RANGE_ADDR = 8'h40,
  parameter logic [7:0]  STAT_ADDR  = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [TIME_W-1:0] cyc_time_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_rx_i,
  input  logic [TIME_W-1:0] pkt_stamp_i,
  output logic              pkt_ready_o,
  output logic              pkt_go_o,
  output logic              pkt_drop_o,
  output logic              tx_late_o,
  output logic              rx_late_o
);
  localparam int unsigned N_EVT = 2;

  cyc_time_t         now, stamp;
  logic [DATA_W-1:0] range_val;
  logic [N_EVT-1:0]  late_evt, stat_q;
  logic in_range, zero, accept, late, go_now, hold_load, busy, rel;
  logic go_q, drop_q, tx_late_q, rx_late_q;
  dir_e dir;

  assign now   = cyc_time_t'(cyc_time_i);
  assign stamp = cyc_time_t'(pkt_stamp_i);
  assign dir   = dir_e'(pkt_rx_i);

  plj_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT),
    .RANGE_ADDR(RANGE_ADDR), .STAT_ADDR(STAT_ADDR)
  ) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .evt_i(late_evt), .range_o(range_val), .stat_o(stat_q)
  );

  plj_diff #(.CNT_WRAP(CNT_WRAP), .OFF_WRAP(OFF_WRAP), .RANGE_W(DATA_W)) i_diff (
    .stamp_i(stamp), .now_i(now), .range_i(range_val),
    .in_range_o(in_range), .zero_o(zero)
  );

  plj_hold i_hold (
    .clk_i, .rst_ni, .load_i(hold_load), .stamp_i(stamp), .now_i(now),
    .busy_o(busy), .release_o(rel)
  );

  assign pkt_ready_o = !busy;
  assign accept      = pkt_valid_i && !busy;
  assign late        = accept && !in_range;
  assign go_now      = accept && in_range && ((dir == DIR_TX) || zero);
  assign hold_load   = accept && in_range && (dir == DIR_RX) && !zero;
  assign late_evt    = {late && (dir == DIR_RX), late && (dir == DIR_TX)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q      <= 1'b0;
      drop_q    <= 1'b0;
      tx_late_q <= 1'b0;
      rx_late_q <= 1'b0;
    end else begin
      go_q      <= go_now | rel;
      drop_q    <= late;
      tx_late_q <= late_evt[0];
      rx_late_q <= late_evt[1];
    end
  end

  assign pkt_go_o   = go_q;
  assign pkt_drop_o = drop_q;
  assign tx_late_o  = tx_late_q;
  assign rx_late_o  = rx_late_q;
endmodule

// File: rtl/pkt_late_judge_sva.sv
module pkt_late_judge_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pkt_valid_i,
  input logic       pkt_rx_i,
  input logic       pkt_ready_o,
  input logic       pkt_go_o,
  input logic       pkt_drop_o,
  input logic       tx_late_o,
  input logic       rx_late_o,
  input logic [1:0] stat_q
);
  p_go_drop_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_go_o && pkt_drop_o));
  p_drop_one_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_drop_o |-> $onehot({tx_late_o, rx_late_o}));
  p_late_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_late_o || rx_late_o) |-> pkt_drop_o);
  p_sticky_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_late_o |-> stat_q[0]);
  p_sticky_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_late_o |-> stat_q[1]);
  p_hold_rx_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pkt_ready_o) |-> $past(pkt_valid_i && pkt_rx_i));
  p_release_go_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_ready_o) |-> pkt_go_o);
  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_ready_o) |=> !pkt_drop_o);
endmodule

bind pkt_late_judge pkt_late_judge_sva i_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid_i), .pkt_rx_i(pkt_rx_i),
  .pkt_ready_o(pkt_ready_o), .pkt_go_o(pkt_go_o), .pkt_drop_o(pkt_drop_o),
  .tx_late_o(tx_late_o), .rx_late_o(rx_late_o), .stat_q(stat_q)
);

// File: tb/test_pkt_late_judge.sv
`timescale 1ns/1ps
module test_pkt_late_judge;
  localparam int CW = 3072;
  localparam int TT = 8000 * CW;

  logic clk = 0, rst_n = 0;
  logic we = 0, valid = 0, rx = 0;
  logic [7:0]  addr = 8'h40;
  logic [15:0] wdata = '0, rdata;
  logic [24:0] cyc = '0, stamp = '0;
  logic ready, go, drop, txl, rxl;
  int total = 0, bad = 0;
  logic [15:0] rng = '0;

  always #4 clk = ~clk;

  pkt_late_judge i_pkt_late_judge (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cyc_time_i(cyc), .pkt_valid_i(valid), .pkt_rx_i(rx),
    .pkt_stamp_i(stamp), .pkt_ready_o(ready), .pkt_go_o(go), .pkt_drop_o(drop),
    .tx_late_o(txl), .rx_late_o(rxl)
  );

  function automatic logic [24:0] mk(int t);
    int n = ((t % TT) + TT) % TT;
    return {13'(n / CW), 12'(n % CW)};
  endfunction

  function automatic int dmod(int ts, int ct);
    return (((ts - ct) % TT) + TT) % TT;
  endfunction

  function automatic bit in_rng(int ts, int ct, logic [15:0] r);
    int d = dmod(ts, ct);
    int thr = int'(r[15:8]) * CW + int'(r[7:0]) * 16;
    return (d < 4000 * CW) && (d <= thr);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_rng(logic [15:0] r);
    wr(8'h40, r);
    rng = r;
  endtask

  // poke: offer a late packet while the hold slot is full (R8)
  task automatic send(bit dir, int ts, int ct, string req, bit poke);
    bit ok = in_rng(ts, ct, rng);
    bit z = dmod(ts, ct) == 0;
    cyc = mk(ct); stamp = mk(ts); rx = dir; valid = 1;
    @(negedge clk);
    valid = 0;
    if (!ok) begin
      chk(drop && !go && txl == !dir && rxl == dir, req, "late drop",
          {go, drop, txl, rxl}, {3'b010, !dir, dir});
    end else if (!dir || z) begin
      chk(go && !drop && !txl && !rxl, req, "go now", {go, drop}, 2'b10);
    end else begin
      chk(!go && !drop && !ready, req, "held", {go, drop, ready}, 3'b000);
      if (poke) begin
        stamp = mk(ct - 5000); rx = 0; valid = 1;
        @(negedge clk);
        valid = 0;
        chk(!drop && !go && !txl && !ready, "R8", "ignored while busy",
            {go, drop, txl, ready}, 4'b0000);
      end
      cyc = mk(ts - 1);
      @(negedge clk);
      chk(!go && !ready, "R5", "no early release", {go, ready}, 2'b00);
      cyc = mk(ts);
      @(negedge clk);
      chk(go && ready, "R5", "release at match", {go, ready}, 2'b11);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    void'($urandom(32'h5eed_1394));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h40, v); chk(v == 16'h0, "R1", "range reset", v, 0);
    rd(8'h41, v); chk(v == 16'h0, "R7", "status reset", v, 0);
    chk(ready && !go && !drop, "R1", "idle outputs", {ready, go, drop}, 3'b100);

    set_rng(16'h0310);
    rd(8'h40, v); chk(v == 16'h0310, "R1", "range readback", v, 16'h0310);

    base = 100 * CW + 50;
    send(0, base, base, "R3", 0);
    send(0, base + 3 * CW + 256, base, "R2", 0);
    send(0, base + 3 * CW + 256 + 16, base, "R2", 0);
    send(0, base - 1, base, "R4", 0);
    rd(8'h41, v); chk(v == 16'h1, "R7", "tx sticky", v, 1);
    wr(8'h41, 16'h1);
    rd(8'h41, v); chk(v == 16'h0, "R7", "w1c clears", v, 0);

    send(1, base, base, "R6", 0);
    send(1, base + 100, base, "R5", 1);
    send(1, base + 9 * CW, base, "R4", 0);
    rd(8'h41, v); chk(v == 16'h2, "R7", "rx sticky", v, 2);

    // set and clear in the same cycle: set wins
    cyc = mk(base); stamp = mk(base - 40); rx = 1; valid = 1;
    we = 1; addr = 8'h41; wdata = 16'h2;
    @(negedge clk);
    valid = 0; we = 0;
    rd(8'h41, v); chk(v == 16'h2, "R7", "set beats clear", v, 2);
    wr(8'h41, 16'h3);

    base = 7999 * CW + 3000;
    send(0, base + 200, base, "R9", 0);
    send(1, base + 2 * CW, base, "R9", 0);
    send(0, base + 4 * CW, base, "R9", 0);

    set_rng(16'h00C0);
    send(0, 500 + CW, 500, "R2", 0);
    send(0, 500 + CW + 1, 500, "R2", 0);

    for (int i = 0; i < 400; i++) begin
      int ct, dl, thr;
      if (i % 50 == 0)
        set_rng({8'($urandom_range(0, 255)), 8'($urandom_range(0, 192))});
      thr = int'(rng[15:8]) * CW + int'(rng[7:0]) * 16;
      ct = int'($urandom_range(0, TT - 1));
      case ($urandom_range(0, 3))
        0: dl = thr + int'($urandom_range(0, 2)) * 16 - 16;
        1: dl = int'($urandom_range(0, 5000)) + thr / 2;
        2: dl = -int'($urandom_range(1, 5000));
        default: dl = int'($urandom_range(0, TT - 1));
      endcase
      send($urandom_range(0, 1) == 1, ct + dl, ct, "R2", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule